// File: doc/BRIEF.md
# DMA Channel Command and Status Register Bank

This block holds the per-channel command and status registers for a small DMA controller. Each channel has one 8-bit register. The register holds a channel enable, a chaining option and a completion flag, and takes two self-clearing command bits: one that starts a transfer and one that aborts it. Software reaches the registers through a simple select/write/address port. Writes can cover the whole byte or only the bits picked by a mask. The channel engines send completion pulses and hardware requests in. The bank answers with one-cycle start and abort pulses and a live enable level for each channel.

The completion flag is set by a completion pulse and cleared by any read of its register. When chaining is on, the enable bit survives the end of a transfer, and hardware requests keep being accepted without software first reading the flag. A non-maskable interrupt input stops every channel at once.

Top module: `dma_ctl_bank`

## Requirements
- R1: After reset every register reads 0x00, every `chan_en` bit is 0, and no start or abort pulse is driven.
- R2: Channel n's register sits at address n*2 (0x0, 0x2, 0x4, 0x6). Read layout: bit 7 completion flag, bit 3 chaining, bit 0 enable. Bits 6..4, 2 and 1 always read 0. An access to any other address reads 0x00 and changes nothing.
- R3: A write updates only the bits whose `bus_wmask` bit is 1, and a byte write uses mask 0xFF. Bit 3 stores chaining and bit 0 stores enable. Writes to bits 7..4 have no effect.
- R4: A `xfer_done` pulse sets the completion flag. A read returns the register value from before the clock edge and then clears the flag. If a read and a completion land in the same cycle, the flag is 1 afterwards.
- R5: A 1 written to bit 1 (with mask bit 1 set) produces a start pulse in the next cycle only if, before the write, enable was 1 and the completion flag was 0. Otherwise it has no effect.
- R6: A 1 written to bit 2 (with mask bit 2 set) produces an abort pulse in the next cycle and leaves enable at 0, whatever was written to bit 0. No start pulse is produced for that channel from that cycle.
- R7: A rising edge on `nmi` produces an abort pulse on every channel in the next cycle. While `nmi` is high, every enable is held at 0. Holding `nmi` high gives no further abort pulses.
- R8: On a completion, enable becomes 0 if chaining is 0 and stays 1 if chaining is 1. Clearing on completion takes priority over a same-cycle write of enable.
- R9: A `hw_req` is accepted when enable is 1 and either chaining is 1 or the completion flag is 0. An accepted request gives a start pulse in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | AW | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wmask | input | 8 | Per-bit write mask |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| xfer_done | input | NCH | Per-channel completion pulse |
| hw_req | input | NCH | Per-channel hardware request |
| nmi | input | 1 | Non-maskable interrupt |
| start_pulse | output | NCH | One-cycle start to channel engines |
| abort_pulse | output | NCH | One-cycle forced termination |
| chan_en | output | NCH | Enable state per channel |

## Verification
The bench targets several corner cases:
- A read that coincides with a completion. A design that clears the flag there would lose the completion.
- A software trigger while the flag is still set. A design that ignores the flag would start a transfer software never cleared.
- A hardware request against a set flag, tried with chaining off and with chaining on. Getting this wrong either stalls a chained channel or restarts an unchained one.
- Initialize and trigger written together. A design that does not suppress the start would begin a transfer on a dying channel.
- `nmi` held high. A level-based abort would pulse every cycle.
- A write to enable while `nmi` is held high, and an enable write in the same cycle as a completion with chaining off. A design with the wrong priority would leave a channel enabled in either case.

// File: rtl/dmacb_pkg.sv
package dmacb_pkg;
   localparam int REG_W  = 8;
   localparam int B_FLAG = 7;
   localparam int B_CHN  = 3;
   localparam int B_KILL = 2;
   localparam int B_TRIG = 1;
   localparam int B_EN   = 0;

   typedef struct packed {
      logic             chain;
      logic             en;
      logic             flag;
   } dmacb_state_t;
endpackage

// File: rtl/dmacb_decode.sv
module dmacb_decode #(
   parameter int NCH    = 4,
   parameter int AW     = 4,
   parameter int STRIDE = 2
) (
   input  logic           sel,
   input  logic           wr,
   input  logic [AW-1:0]  addr,
   output logic [NCH-1:0] wr_hit,
   output logic [NCH-1:0] rd_hit
);
   localparam bit POW2 = ((STRIDE & (STRIDE - 1)) == 0);
   localparam int LG   = (STRIDE > 1) ? $clog2(STRIDE) : 0;

   if (NCH * STRIDE > (1 << AW)) begin : g_bad_span
      $error("dmacb_decode: address window too small");
   end

   logic [NCH-1:0] hit;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      if (POW2) begin : g_shift
         assign hit[i] = (addr == (AW'(i) << LG));
      end else begin : g_mul
         assign hit[i] = (addr == AW'(i * STRIDE));
      end
      assign wr_hit[i] = sel & wr & hit[i];
      assign rd_hit[i] = sel & ~wr & hit[i];
   end
endmodule

// File: rtl/dmacb_chan.sv
module dmacb_chan
   import dmacb_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_hit,
   input  logic             rd_hit,
   input  logic [REG_W-1:0] wdata,
   input  logic [REG_W-1:0] wmask,
   input  logic             done,
   input  logic             hw_req,
   input  logic             nmi_lvl,
   input  logic             nmi_rise,
   output logic             start_pulse,
   output logic             abort_pulse,
   output logic             en,
   output logic [REG_W-1:0] rd_val
);
   dmacb_state_t st_q, st_d;
   logic cmd_kill, cmd_trig, abort_now, clr_en;
   logic trig_ok, hw_ok, start_d;

   assign cmd_kill  = wr_hit & wmask[B_KILL] & wdata[B_KILL];
   assign cmd_trig  = wr_hit & wmask[B_TRIG] & wdata[B_TRIG];
   assign abort_now = cmd_kill | nmi_rise;
   assign clr_en    = abort_now | nmi_lvl;
   assign trig_ok   = cmd_trig & st_q.en & ~st_q.flag;
   assign hw_ok     = hw_req & st_q.en & (st_q.chain | ~st_q.flag);
   assign start_d   = (trig_ok | hw_ok) & ~clr_en;

   always_comb begin
      st_d = st_q;
      if (wr_hit && wmask[B_CHN]) st_d.chain = wdata[B_CHN];
      if (clr_en)                         st_d.en = 1'b0;
      else if (done && !st_q.chain)       st_d.en = 1'b0;
      else if (wr_hit && wmask[B_EN])     st_d.en = wdata[B_EN];
      if (done)        st_d.flag = 1'b1;
      else if (rd_hit) st_d.flag = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= '0;
         start_pulse <= 1'b0;
         abort_pulse <= 1'b0;
      end else begin
         st_q        <= st_d;
         start_pulse <= start_d;
         abort_pulse <= abort_now;
      end
   end

   assign en = st_q.en;

   always_comb begin
      rd_val         = '0;
      rd_val[B_FLAG] = st_q.flag;
      rd_val[B_CHN]  = st_q.chain;
      rd_val[B_EN]   = st_q.en;
   end

   // R4
   read_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && !done) |=> !rd_val[B_FLAG]);
   // R4
   done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> rd_val[B_FLAG]);
   // R5
   start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> $past(en));
   // R6
   abort_leaves_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_pulse |-> (!en && !start_pulse));
   // R8
   unchained_done_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !rd_val[B_CHN]) |=> !en);
   // R8
   chained_done_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rd_val[B_CHN] && en && !wr_hit && !nmi_lvl && !nmi_rise) |=> en);
   // R9
   chained_hw_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_req && en && rd_val[B_CHN] && !wr_hit && !nmi_lvl && !nmi_rise) |=> start_pulse);
endmodule

// File: rtl/dmacb_rmux.sv
module dmacb_rmux
   import dmacb_pkg::*;
#(
   parameter int NCH = 4
) (
   input  logic [NCH-1:0]       rd_hit,
   input  logic [NCH*REG_W-1:0] vals,
   output logic [REG_W-1:0]     rdata
);
   always_comb begin
      rdata = '0;
      for (int i = 0; i < NCH; i++)
         rdata |= vals[i*REG_W +: REG_W] & {REG_W{rd_hit[i]}};
   end
endmodule

// File: rtl/dma_ctl_bank.sv
module dma_ctl_bank
   import dmacb_pkg::*;
#(
   parameter int NCH    = 4,
   parameter int AW     = 4,
   parameter int STRIDE = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [AW-1:0]    bus_addr,
   input  logic [7:0]       bus_wdata,
   input  logic [7:0]       bus_wmask,
   output logic [7:0]       bus_rdata,
   input  logic [NCH-1:0]   xfer_done,
   input  logic [NCH-1:0]   hw_req,
   input  logic             nmi,
   output logic [NCH-1:0]   start_pulse,
   output logic [NCH-1:0]   abort_pulse,
   output logic [NCH-1:0]   chan_en
);
   if (NCH < 1) begin : g_bad_nch
      $error("dma_ctl_bank: NCH must be at least 1");
   end
   if (STRIDE < 1) begin : g_bad_stride
      $error("dma_ctl_bank: STRIDE must be at least 1");
   end

   logic [NCH-1:0]       wr_hit, rd_hit;
   logic [NCH*REG_W-1:0] vals;
   logic                 nmi_q, nmi_rise;

   always_ff @(posedge clk) begin
      if (!rst_n) nmi_q <= 1'b0;
      else        nmi_q <= nmi;
   end
   assign nmi_rise = nmi & ~nmi_q;

   dmacb_decode #(.NCH(NCH), .AW(AW), .STRIDE(STRIDE)) u_dec (
      .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
      .wr_hit(wr_hit), .rd_hit(rd_hit)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_chan
      dmacb_chan u_ch (
         .clk(clk), .rst_n(rst_n),
         .wr_hit(wr_hit[i]), .rd_hit(rd_hit[i]),
         .wdata(bus_wdata), .wmask(bus_wmask),
         .done(xfer_done[i]), .hw_req(hw_req[i]),
         .nmi_lvl(nmi), .nmi_rise(nmi_rise),
         .start_pulse(start_pulse[i]), .abort_pulse(abort_pulse[i]),
         .en(chan_en[i]), .rd_val(vals[i*REG_W +: REG_W])
      );
   end

   dmacb_rmux #(.NCH(NCH)) u_rmux (.rd_hit(rd_hit), .vals(vals), .rdata(bus_rdata));

   // R7
   nmi_aborts_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nmi) |=> (&abort_pulse));
   // R7
   nmi_holds_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nmi |=> (chan_en == '0));
   // R2
   single_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_hit | rd_hit));
endmodule

// File: tb/sim_dma_ctl_bank.sv
`timescale 1ns/1ps
module sim_dma_ctl_bank;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0, nmi = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0, bus_wmask = '0, bus_rdata;
   logic [3:0] xfer_done = '0, hw_req = '0, start_pulse, abort_pulse, chan_en;
   int total = 0, bad = 0;
   bit ended = 0;

   always #4 clk = ~clk;

   dma_ctl_bank u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wmask(bus_wmask),
      .bus_rdata(bus_rdata), .xfer_done(xfer_done), .hw_req(hw_req), .nmi(nmi),
      .start_pulse(start_pulse), .abort_pulse(abort_pulse), .chan_en(chan_en)
   );

   typedef struct packed {
      logic [1:0] op;   // 0 idle, 1 write, 2 read
      logic [3:0] addr;
      logic [7:0] wd;
      logic [7:0] wm;
      logic [3:0] done;
      logic [3:0] hw;
      logic       nmi;
      logic [7:0] erd;
      logic [3:0] est;
      logic [3:0] eab;
      logic [3:0] een;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 29;
   localparam vec_t VECS [NV] = '{
      '{2'd1,4'h0,8'h01,8'hFF,4'h0,4'h0,1'b0,8'h00,4'h0,4'h0,4'h1,4'd3}, // R3
      '{2'd1,4'h0,8'h02,8'h02,4'h0,4'h0,1'b0,8'h00,4'h1,4'h0,4'h1,4'd5}, // R5
      '{2'd0,4'h0,8'h00,8'h00,4'h1,4'h0,1'b0,8'h00,4'h0,4'h0,4'h0,4'd8}, // R8
      '{2'd2,4'h0,8'h00,8'h00,4'h0,4'h0,1'b0,8'h80,4'h0,4'h0,4'h0,4'd4}, // R4
      '{2'd2,4'h0,8'h00,8'h00,4'h0,4'h0,1'b0,8'h00,4'h0,4'h0,4'h0,4'd4}, // R4
      '{2'd1,4'h2,8'h09,8'hFF,4'h0,4'h0,1'b0,8'h00,4'h0,4'h0,4'h2,4'd3}, // R3
      '{2'd0,4'h0,8'h00,8'h00,4'h2,4'h0,1'b0,8'h00,4'h0,4'h0,4'h2,4'd8}, // R8
      '{2'd0,4'h0,8'h00,8'h00,4'h0,4'h2,1'b0,8'h00,4'h2,4'h0,4'h2,4'd9}, // R9
      '{2'd1,4'h2,8'h02,8'h02,4'h0,4'h0,1'b0,8'h00,4'h0,4'h0,4'h2,4'd5}, // R5
      '{2'd2,4'h2,8'h00,8'h00,4'h0,4'h0,1'b0,8'h89,4'h0,4'h0,4'h2,4'd2}, // R2
      '{2'd1,4'h2,8'h02,8'h02,4'h0,4'h0,1'b0,8'h00,4'h2,4'h0,4'h2,4'd5}, // R5
      '{2'd1,4'h4,8'h01,8'hFF,4'h0,4'h0,1'b0,8'h00,4'h0,4'h0,4'h6,4'd3}, // R3
      '{2'd0,4'h0,8'h00,8'h00,4'h4,4'h0,1'b0,8'h00,4'h0,4'h0,4'h2,4'd8}, // R8
      '{2'd1,4'h4,8'h01,8'h01,4'h0,4'h0,1'b0,8'h00,4'h0,4'h0,4'h6,4'd3}, // R3
      '{2'd0,4'h0,8'h00,8'h00,4'h0,4'h4,1'b0,8'h00,4'h0,4'h0,4'h6,4'd9}, // R9
      '{2'd2,4'h4,8'h00,8'h00,4'h4,4'h0,1'b0,8'h81,4'h0,4'h0,4'h2,4'd4}, // R4
      '{2'd2,4'h4,8'h00,8'h00,4'h0,4'h0,1'b0,8'h80,4'h0,4'h0,4'h2,4'd4}, // R4
      '{2'd2,4'h4,8'h00,8'h00,4'h0,4'h0,1'b0,8'h00,4'h0,4'h0,4'h2,4'd4}, // R4
      '{2'd0,4'h0,8'h00,8'h00,4'h0,4'h8,1'b0,8'h00,4'h0,4'h0,4'h2,4'd9}, // R9
      '{2'd1,4'h4,8'h05,8'hFF,4'h0,4'h0,1'b0,8'h00,4'h0,4'h4,4'h2,4'd6}, // R6
      '{2'd1,4'h6,8'hF1,8'hFF,4'h0,4'h0,1'b0,8'h00,4'h0,4'h0,4'hA,4'd3}, // R3
      '{2'd2,4'h6,8'h00,8'h00,4'h0,4'h0,1'b0,8'h01,4'h0,4'h0,4'hA,4'd2}, // R2
      '{2'd0,4'h0,8'h00,8'h00,4'h0,4'hA,1'b0,8'h00,4'hA,4'h0,4'hA,4'd9}, // R9
      '{2'd0,4'h0,8'h00,8'h00,4'h0,4'h0,1'b1,8'h00,4'h0,4'hF,4'h0,4'd7}, // R7
      '{2'd1,4'h0,8'h01,8'h01,4'h0,4'h0,1'b1,8'h00,4'h0,4'h0,4'h0,4'd7}, // R7
      '{2'd1,4'h0,8'h01,8'hFF,4'h0,4'h0,1'b0,8'h00,4'h0,4'h0,4'h1,4'd3}, // R3
      '{2'd1,4'h1,8'h00,8'hFF,4'h0,4'h0,1'b0,8'h00,4'h0,4'h0,4'h1,4'd2}, // R2
      '{2'd2,4'h1,8'h00,8'h00,4'h0,4'h0,1'b0,8'h00,4'h0,4'h0,4'h1,4'd2}, // R2
      '{2'd1,4'h0,8'h06,8'h06,4'h0,4'h0,1'b0,8'h00,4'h0,4'h1,4'h0,4'd6}  // R6
   };

   task automatic chk(input int req, input string what, input logic [7:0] got, input logic [7:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL R%0d %s: actual=%h expected=%h", req, what, got, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      bus_sel   = (v.op != 2'd0);
      bus_wr    = (v.op == 2'd1);
      bus_addr  = v.addr;
      bus_wdata = v.wd;
      bus_wmask = v.wm;
      xfer_done = v.done;
      hw_req    = v.hw;
      nmi       = v.nmi;
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      finish_run();
   end

   initial begin
      vec_t idle;
      idle = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(1, "en after reset", {4'h0, chan_en}, 8'h00);
      chk(1, "pulses after reset", {start_pulse, abort_pulse}, 8'h00);
      for (int a = 0; a < 8; a += 2) begin
         bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'(a);
         #1 chk(1, "reg after reset", bus_rdata, 8'h00);
         @(negedge clk);
      end
      apply(idle);
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         apply(VECS[i]);
         #1;
         if (VECS[i].op == 2'd2) chk(int'(VECS[i].req), "read data", bus_rdata, VECS[i].erd);
         @(posedge clk);
         @(negedge clk);
         chk(int'(VECS[i].req), "start", {4'h0, start_pulse}, {4'h0, VECS[i].est});
         chk(int'(VECS[i].req), "abort", {4'h0, abort_pulse}, {4'h0, VECS[i].eab});
         chk(int'(VECS[i].req), "enable", {4'h0, chan_en}, {4'h0, VECS[i].een});
      end
      apply(idle);
      @(negedge clk);

      // R8: completion with chaining off beats a same-cycle enable write
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h2; bus_wdata = 8'h01; bus_wmask = 8'hFF;
      @(negedge clk);
      bus_wmask = 8'h01; xfer_done = 4'h2;
      @(negedge clk);
      apply(idle);
      chk(8, "done vs write", {4'h0, chan_en}, 8'h00);

      // R1: reset in mid-run clears state
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h6; bus_wdata = 8'h09; bus_wmask = 8'hFF;
      @(negedge clk);
      apply(idle);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      bus_sel = 1'b1; bus_addr = 4'h6;
      #1 chk(1, "reg after mid reset", bus_rdata, 8'h00);
      chk(1, "en after mid reset", {4'h0, chan_en}, 8'h00);
      @(negedge clk);
      apply(idle);
      @(negedge clk);
      finish_run();
   end
endmodule